// File: doc/BRIEF.md
# Electrically Erasable Read-Only Memory Mode Controller

This block is a synthesizable, clocked model of a byte-wide erasable read-only memory. It presents the external pins of such a memory: a 17-bit address, an 8-bit data bus split into input, output and output-enable, and active-low chip select, output enable and write strobe. Two digital flags take the place of analog levels. One stands for the raised programming supply. The other stands for the high voltage on address bit 9. Every clock cycle the pin state is decoded into one operating mode: standby, inhibit, output disable, read, identifier, verify, program or erase. Program and erase are applied to a register array. The data bus is driven only in the modes that read.

A program only clears bits: the stored byte becomes the old byte ANDed with the data. An erase sets every byte to ones. Both take effect when the write strobe returns high. The delay from output enable to driven data, and the hold time before the bus floats, are parameters counted in clock cycles. Storage depth is a parameter. The index is the low address bits, so a small array can stand in for the full one in simulation.

Top module: `eprom_mode_ctrl`

## Requirements
- R1: After reset every stored byte reads FF hex and `dq_oe` is low.
- R2: While `sel_n` is high, `dq_oe` is low in that same cycle, whatever `rd_n` and `wr_n` do. A write-strobe pulse is cancelled if `sel_n` is high at the last clock edge of the pulse or at the edge that commits it.
- R3: With `sel_n` low and `rd_n` high, `dq_oe` stays low.
- R4: With `sel_n` low, `rd_n` low and `hv_a9` low, once driving, `dq_out` equals the byte stored at index `addr[STORE_AW-1:0]`.
- R5: Program: `vpp_on`=1, `sel_n`=0, `rd_n`=1, `hv_a9`=0 and `wr_n` low for at least one clock edge. At the first edge where `wr_n` is seen high again, the byte at the address captured during the pulse becomes old AND the captured data. Bits are never set by a program.
- R6: Erase: `vpp_on`=1, `sel_n`=0, `rd_n`=1, `hv_a9`=1, all 17 address bits zero and `dq_in`=FF hex, then a `wr_n` pulse. This sets every stored byte to FF hex.
- R7: A write-strobe pulse with `hv_a9`=1 and `vpp_on`=1 changes nothing when any address bit is one or when `dq_in` is not FF hex.
- R8: With `sel_n`=0, `rd_n`=0, `hv_a9`=1 and `vpp_on`=0, `dq_out` is DA hex when `addr[0]`=0 and 01 hex when `addr[0]`=1.
- R9: Verify: with `vpp_on`=1, `sel_n`=0, `rd_n`=0 and `wr_n`=1, `dq_out` is the stored byte, even when `hv_a9`=1.
- R10: `dq_oe` rises at the OE_DLY-th clock edge at which `sel_n` and `rd_n` are both seen low, and not earlier.
- R11: When `rd_n` goes high, `dq_oe` stays high through DF_DLY-1 edges and falls at the DF_DLY-th edge.
- R12: A write-strobe pulse with `vpp_on`=0 changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 17 | Byte address |
| dq_in | input | 8 | Data bus as seen by the block (program data) |
| dq_out | output | 8 | Data bus value when driven, zero otherwise |
| dq_oe | output | 1 | High while the block drives the data bus |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Program/erase strobe, active low |
| vpp_on | input | 1 | Raised programming supply present |
| hv_a9 | input | 1 | High voltage present on address bit 9 |

## Verification
A bad byte in the array shows on the next read or verify of that address, OE_DLY cycles after output enable falls. A missed erase therefore shows at the first location read afterwards. A wrong mode decode shows at once as a bus that is driven or floating when it should not be, or as identifier bytes where array data belongs. An output-timer count that is off by one moves the `dq_oe` edge by a cycle, which a check sampled cycle by cycle catches. A wrong AND-merge shows as bits set on a second program of the same byte.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

   typedef enum logic [3:0] {
      MD_STANDBY,
      MD_INHIBIT,
      MD_DISABLE,
      MD_READ,
      MD_IDENT,
      MD_VERIFY,
      MD_PROGRAM,
      MD_ERASE
   } eprom_mode_e;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_PROG,
      OP_ERASE
   } eprom_op_e;

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
   import eprom_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              sel_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              vpp_on,
   input  logic              hv_a9,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output eprom_mode_e       mode,
   output eprom_op_e         op,
   output logic              drive_req,
   output logic              id_sel
);

   logic erase_shape;

   // erase needs a blank address and all-ones data on the bus
   assign erase_shape = (addr == '0) && (dq_in == {DATA_W{1'b1}});

   always_comb begin
      if (sel_n) begin
         mode = vpp_on ? MD_INHIBIT : MD_STANDBY;
      end else if (!rd_n) begin
         if (hv_a9 && !vpp_on)
            mode = MD_IDENT;
         else if (vpp_on)
            mode = MD_VERIFY;
         else
            mode = MD_READ;
      end else if (vpp_on && !wr_n) begin
         if (hv_a9)
            mode = erase_shape ? MD_ERASE : MD_DISABLE;
         else
            mode = MD_PROGRAM;
      end else begin
         mode = MD_DISABLE;
      end
   end

   always_comb begin
      case (mode)
         MD_PROGRAM: op = OP_PROG;
         MD_ERASE:   op = OP_ERASE;
         default:    op = OP_NONE;
      endcase
   end

   assign drive_req = (mode == MD_READ) || (mode == MD_IDENT) || (mode == MD_VERIFY);
   assign id_sel    = (mode == MD_IDENT);

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
   parameter int STORE_AW = 6,
   parameter int DATA_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                commit_prog,
   input  logic                commit_erase,
   input  logic [STORE_AW-1:0] wr_idx,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [STORE_AW-1:0] rd_idx,
   output logic [DATA_W-1:0]   rd_data
);

   localparam int DEPTH = 1 << STORE_AW;
   localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n || commit_erase) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= BLANK;
      end else if (commit_prog) begin
         mem_q[wr_idx] <= mem_q[wr_idx] & wr_data;
      end
   end

   assign rd_data = mem_q[rd_idx];

   // R5: a program never raises a bit
   a_r5_prog_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
      commit_prog |=> ((mem_q[$past(wr_idx)] & ~$past(mem_q[wr_idx])) == '0));

   // R6: an erase leaves the first and last word blank
   a_r6_erase_blank: assert property (@(posedge clk) disable iff (!rst_n)
      commit_erase |=> (mem_q[0] == BLANK && mem_q[DEPTH-1] == BLANK));

endmodule

// File: rtl/eprom_out_timer.sv
module eprom_out_timer #(
   parameter int OE_DLY = 3,
   parameter int DF_DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic sel_n,
   output logic drive_en
);

   localparam int OCW = $clog2(OE_DLY + 1);
   localparam int FCW = $clog2(DF_DLY + 1);
   localparam logic [OCW-1:0] ON_MAX   = OCW'(OE_DLY);
   localparam logic [OCW-1:0] ON_LAST  = OCW'(OE_DLY - 1);
   localparam logic [FCW-1:0] OFF_MAX  = FCW'(DF_DLY);
   localparam logic [FCW-1:0] OFF_LAST = FCW'(DF_DLY - 1);

   logic [OCW-1:0] on_cnt;
   logic [FCW-1:0] off_cnt;
   logic           en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         on_cnt  <= '0;
         off_cnt <= '0;
         en_q    <= 1'b0;
      end else if (req) begin
         off_cnt <= '0;
         if (on_cnt < ON_MAX) on_cnt <= on_cnt + 1'b1;
         if (on_cnt >= ON_LAST) en_q <= 1'b1;
      end else begin
         on_cnt <= '0;
         if (off_cnt < OFF_MAX) off_cnt <= off_cnt + 1'b1;
         if (en_q && off_cnt >= OFF_LAST) en_q <= 1'b0;
      end
   end

   // deselect floats the bus without waiting for the hold count
   assign drive_en = en_q & ~sel_n;

   // R10: the driver cannot turn on one edge after an idle cycle
   a_r10_no_early_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (!req && !en_q) |=> !en_q);

   generate
      if (DF_DLY >= 2) begin : g_hold_chk
         // R11: driver holds across the first edge after output enable rises
         a_r11_float_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(req) && en_q) |=> en_q);
      end
   endgenerate

endmodule

// File: rtl/eprom_mode_ctrl.sv
module eprom_mode_ctrl
   import eprom_pkg::*;
#(
   parameter int          ADDR_W   = 17,
   parameter int          DATA_W   = 8,
   parameter int          STORE_AW = 6,
   parameter int          OE_DLY   = 3,
   parameter int          DF_DLY   = 2,
   parameter logic [7:0]  MFR_ID   = 8'hDA,
   parameter logic [7:0]  DEV_ID   = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   input  logic              sel_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              vpp_on,
   input  logic              hv_a9
);

   generate
      if (STORE_AW < 1 || STORE_AW > ADDR_W) begin : g_bad_aw
         $error("STORE_AW must lie in 1..ADDR_W");
      end
      if (OE_DLY < 1 || DF_DLY < 1) begin : g_bad_dly
         $error("OE_DLY and DF_DLY must be at least 1");
      end
      if (DATA_W != 8) begin : g_bad_dw
         $error("identifier bytes need DATA_W of 8");
      end
   endgenerate

   eprom_mode_e       mode;
   eprom_op_e         op_now;
   logic              drive_req;
   logic              id_sel;
   logic [STORE_AW-1:0] idx_now;

   eprom_mode_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .sel_n     (sel_n),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .vpp_on    (vpp_on),
      .hv_a9     (hv_a9),
      .addr      (addr),
      .dq_in     (dq_in),
      .mode      (mode),
      .op        (op_now),
      .drive_req (drive_req),
      .id_sel    (id_sel)
   );

   generate
      if (STORE_AW == ADDR_W) begin : g_full_idx
         assign idx_now = addr;
      end else begin : g_alias_idx
         assign idx_now = addr[STORE_AW-1:0];
      end
   endgenerate

   // strobe tracking: the last sample of the pulse arms the operation
   logic                wr_q;
   eprom_op_e           op_q;
   logic [STORE_AW-1:0] idx_q;
   logic [DATA_W-1:0]   data_q;
   logic                strobe_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q   <= 1'b1;
         op_q   <= OP_NONE;
         idx_q  <= '0;
         data_q <= '0;
      end else begin
         wr_q <= wr_n;
         if (!wr_n) begin
            op_q   <= op_now;
            idx_q  <= idx_now;
            data_q <= dq_in;
         end else if (!wr_q) begin
            op_q <= OP_NONE;
         end
      end
   end

   assign strobe_rise = wr_n & ~wr_q & ~sel_n;

   logic                commit_prog;
   logic                commit_erase;
   logic [DATA_W-1:0]   cell_byte;

   assign commit_prog  = strobe_rise && (op_q == OP_PROG);
   assign commit_erase = strobe_rise && (op_q == OP_ERASE);

   eprom_cell_array #(.STORE_AW(STORE_AW), .DATA_W(DATA_W)) u_cells (
      .clk          (clk),
      .rst_n        (rst_n),
      .commit_prog  (commit_prog),
      .commit_erase (commit_erase),
      .wr_idx       (idx_q),
      .wr_data      (data_q),
      .rd_idx       (idx_now),
      .rd_data      (cell_byte)
   );

   logic drive_en;

   eprom_out_timer #(.OE_DLY(OE_DLY), .DF_DLY(DF_DLY)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (drive_req),
      .sel_n    (sel_n),
      .drive_en (drive_en)
   );

   logic [DATA_W-1:0] out_byte;

   always_comb begin
      if (id_sel)
         out_byte = addr[0] ? DEV_ID : MFR_ID;
      else
         out_byte = cell_byte;
   end

   assign dq_oe  = drive_en;
   assign dq_out = drive_en ? out_byte : '0;

endmodule

// File: tb/eprom_mode_ctrl_test.sv
module eprom_mode_ctrl_test;

   localparam int OE_D = 3;
   localparam int DF_D = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [16:0] addr = '0;
   logic [7:0]  dq_in = '0;
   logic [7:0]  dq_out;
   logic        dq_oe;
   logic        sel_n = 1'b1;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        vpp_on = 1'b0;
   logic        hv_a9 = 1'b0;

   int total = 0;
   int fails = 0;

   always #5 clk = ~clk;

   eprom_mode_ctrl #(.OE_DLY(OE_D), .DF_DLY(DF_D)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
      .dq_oe(dq_oe), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
      .vpp_on(vpp_on), .hv_a9(hv_a9)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; vpp_on = 1'b0; hv_a9 = 1'b0;
      addr = '0; dq_in = '0;
   endtask

   // read with given flags; returns the byte and whether the bus was driven
   task automatic do_read(input logic [16:0] a, input bit vp, input bit a9,
                          output logic [7:0] val, output bit drv);
      @(negedge clk);
      addr = a; vpp_on = vp; hv_a9 = a9; sel_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
      repeat (OE_D) @(posedge clk);
      @(negedge clk);
      val = dq_out; drv = dq_oe;
      rd_n = 1'b1;
      repeat (DF_D + 1) @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic do_pulse(input logic [16:0] a, input logic [7:0] d,
                           input bit vp, input bit a9);
      @(negedge clk);
      addr = a; dq_in = d; vpp_on = vp; hv_a9 = a9; sel_n = 1'b0; rd_n = 1'b1; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk);
      idle();
   endtask

   task automatic expect_byte(input logic [16:0] a, input logic [7:0] exp, input string tag);
      logic [7:0] v; bit d;
      do_read(a, 1'b0, 1'b0, v, d);
      chk(d == 1'b1 && v == exp, tag, {d, v}, {1'b1, exp});
   endtask

   task automatic t_reset();
      chk(dq_oe == 1'b0, "R1 oe low after reset", dq_oe, 0);
      expect_byte(17'd5, 8'hFF, "R1 blank byte / R4 read");
      expect_byte(17'd63, 8'hFF, "R1 blank last byte");
   endtask

   task automatic t_standby();
      @(negedge clk);
      sel_n = 1'b1; rd_n = 1'b0; wr_n = 1'b0;
      repeat (OE_D + 2) @(posedge clk);
      @(negedge clk);
      chk(dq_oe == 1'b0, "R2 standby floats", dq_oe, 0);
      idle();
      @(negedge clk);
      addr = 17'd9; dq_in = 8'h00; vpp_on = 1'b1; sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b0;
      @(negedge clk); wr_n = 1'b1;
      @(negedge clk); idle();
      expect_byte(17'd9, 8'hFF, "R2 deselected pulse ignored");
   endtask

   task automatic t_disable();
      @(negedge clk);
      sel_n = 1'b0; rd_n = 1'b1;
      repeat (OE_D + 2) @(posedge clk);
      @(negedge clk);
      chk(dq_oe == 1'b0, "R3 output disable floats", dq_oe, 0);
      idle();
   endtask

   task automatic t_program();
      do_pulse(17'd3, 8'hA5, 1'b1, 1'b0);
      expect_byte(17'd3, 8'hA5, "R5 program byte");
      do_pulse(17'd3, 8'h0F, 1'b1, 1'b0);
      expect_byte(17'd3, 8'h05, "R5 program ANDs");
      do_pulse(17'd3, 8'hFF, 1'b1, 1'b0);
      expect_byte(17'd3, 8'h05, "R5 program cannot set bits");
      expect_byte(17'd4, 8'hFF, "R5 neighbour untouched");
   endtask

   task automatic t_no_vpp();
      do_pulse(17'd7, 8'h00, 1'b0, 1'b0);
      expect_byte(17'd7, 8'hFF, "R12 pulse without supply");
   endtask

   task automatic t_abort();
      @(negedge clk);
      addr = 17'd8; dq_in = 8'h00; vpp_on = 1'b1; sel_n = 1'b0; rd_n = 1'b1; wr_n = 1'b0;
      @(negedge clk); sel_n = 1'b1;
      @(negedge clk); wr_n = 1'b1;
      @(negedge clk); idle();
      expect_byte(17'd8, 8'hFF, "R2 pulse cancelled by deselect");
   endtask

   task automatic t_ident();
      logic [7:0] v; bit d;
      do_read(17'd0, 1'b0, 1'b1, v, d);
      chk(d && v == 8'hDA, "R8 maker code", v, 8'hDA);
      do_read(17'd1, 1'b0, 1'b1, v, d);
      chk(d && v == 8'h01, "R8 device code", v, 8'h01);
   endtask

   task automatic t_verify();
      logic [7:0] v; bit d;
      do_read(17'd3, 1'b1, 1'b0, v, d);
      chk(d && v == 8'h05, "R9 verify stored byte", v, 8'h05);
      do_read(17'd3, 1'b1, 1'b1, v, d);
      chk(d && v == 8'h05, "R9 verify under high-voltage flag", v, 8'h05);
   endtask

   task automatic t_timing();
      @(negedge clk);
      addr = 17'd3; sel_n = 1'b0; rd_n = 1'b0;
      repeat (OE_D - 1) @(posedge clk);
      @(negedge clk);
      chk(dq_oe == 1'b0, "R10 not driven before delay", dq_oe, 0);
      @(posedge clk); @(negedge clk);
      chk(dq_oe == 1'b1, "R10 driven at delay", dq_oe, 1);
      rd_n = 1'b1;
      repeat (DF_D - 1) @(posedge clk);
      @(negedge clk);
      chk(dq_oe == 1'b1, "R11 held during float delay", dq_oe, 1);
      @(posedge clk); @(negedge clk);
      chk(dq_oe == 1'b0, "R11 floats after delay", dq_oe, 0);
      rd_n = 1'b0;
      repeat (OE_D) @(posedge clk);
      @(negedge clk);
      sel_n = 1'b1;
      #1;
      chk(dq_oe == 1'b0, "R2 deselect floats at once", dq_oe, 0);
      @(negedge clk);
      idle();
      repeat (DF_D + 1) @(posedge clk);
   endtask

   task automatic t_erase_reject();
      do_pulse(17'd2, 8'hFF, 1'b1, 1'b1);
      expect_byte(17'd3, 8'h05, "R7 erase rejected, address nonzero");
      do_pulse(17'h10000, 8'hFF, 1'b1, 1'b1);
      expect_byte(17'd3, 8'h05, "R7 erase rejected, high address bit");
      do_pulse(17'd0, 8'h7F, 1'b1, 1'b1);
      expect_byte(17'd3, 8'h05, "R7 erase rejected, data not FF");
   endtask

   task automatic t_erase();
      do_pulse(17'd20, 8'h12, 1'b1, 1'b0);
      expect_byte(17'd20, 8'h12, "R5 second location programmed");
      do_pulse(17'd0, 8'hFF, 1'b1, 1'b1);
      expect_byte(17'd3, 8'hFF, "R6 erase byte 3");
      expect_byte(17'd20, 8'hFF, "R6 erase byte 20");
   endtask

   bit done = 1'b0;

   initial begin
      idle();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_standby();
      t_disable();
      t_program();
      t_no_vpp();
      t_abort();
      t_ident();
      t_verify();
      t_timing();
      t_erase_reject();
      t_erase();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule